// File: doc/BRIEF.md
# Repeated-Addition Unsigned Multiplier with Hardwired Sequencer

This block multiplies two unsigned 4-bit operands by adding the multiplicand into an accumulator once per count of the multiplier. Both operands arrive one after the other on a single 4-bit input bus. The multiplicand is taken in the first cycle after reset and the multiplier in the second. A datapath holds the accumulator, the multiplicand and a down-counting copy of the multiplier. A 4-bit adder and a zero detector on the down-counter complete it.

Sequencing is hardwired. A 3-bit state counter feeds a decoder, and the decoder yields one-hot timing states T0..T5. The counter normally increments. Its parallel-load input is raised in two cases. In T3 with a nonzero count it loads T2 to repeat the add pass. In T5 it reloads T5 so the block parks there. The product modulo 16 appears on the output bus for exactly one cycle, flagged by `out_valid`. A new multiplication needs a new reset.

Top module: `rep_add_mult`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the sequencer returns to T0. `out_valid` is 0 and `out_bus` is 0 in the cycle that follows.
- R2: Counting the first cycle after reset release as cycle 0, `in_bus` in cycle 0 becomes the multiplicand and the accumulator is cleared. `in_bus` in cycle 1 becomes the multiplier. `in_bus` in later cycles has no effect on the result.
- R3: Each add pass takes two cycles, T2 then T3. T2 adds the multiplicand into the accumulator and decrements the count. T3 goes back to T2 while the count is nonzero.
- R4: For multiplier n (1..15), `out_valid` is 1 in exactly cycle 2+2n. In that cycle `out_bus` carries (multiplicand × n) mod 16.
- R5: Before the result cycle, `out_valid` is 0 and `out_bus` is 0.
- R6: After the result cycle the block stays in T5 until reset. `out_valid` and `out_bus` remain 0 whatever `in_bus` does.
- R7: A multiplier of 0 wraps the count on its first decrement, giving 16 passes. `out_valid` rises in cycle 34 with `out_bus` = 0.
- R8: A multiplicand of 0 gives a result of 0 after the normal n passes.
- R9: A reset raised in the middle of an operation abandons it. The next operation is timed from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_bus | input | 4 | Shared operand bus: multiplicand in cycle 0, multiplier in cycle 1 |
| out_bus | output | 4 | Product in the result cycle, zero otherwise |
| out_valid | output | 1 | High for the single result cycle (state T4) |

## Verification
The result is due in cycle 2+2n after reset release, where n is the multiplier, or 16 when the multiplier is 0. For the zero multiplier this is cycle 34. Each scenario counts cycles from the release and samples the outputs on the falling edge of every cycle up to six cycles past the expected one. The sample must show the product with `out_valid` high in exactly the predicted cycle, and zeros before and after it. From cycle 2 on, the input bus is driven with changing values, so any late capture of an operand shows up as a wrong product.

// File: rtl/repmul_pkg.sv
package repmul_pkg;

    // Timing state indices; the load targets depend on these positions.
    localparam int ST_T0     = 0;
    localparam int ST_T1     = 1;
    localparam int ST_T2     = 2;
    localparam int ST_T3     = 3;
    localparam int ST_T4     = 4;
    localparam int ST_T5     = 5;
    localparam int ST_USED   = 6;
    localparam int ST_LOOP   = ST_T2;
    localparam int ST_HALT   = ST_T5;

    // One bit per datapath control line.
    typedef struct packed {
        logic clr_acc;    // accumulator <- 0
        logic ld_mcand;   // multiplicand <- in_bus
        logic ld_mplier;  // count <- in_bus
        logic add_en;     // adder output = acc + multiplicand
        logic dec_cnt;    // count <- count - 1
        logic drive_out;  // out_bus <- accumulator
        logic wr_acc;     // accumulator <- adder output
    } ctl_t;

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = load_val;
        end else begin
            s_d.cnt = s_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;
endmodule

// File: rtl/timing_decoder.sv
module timing_decoder #(
    parameter int CNT_W = 3,
    parameter int N_OUT = 6
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [N_OUT-1:0] t
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_dec
        assign t[i] = (cnt == CNT_W'(i));
    end
endmodule

// File: rtl/ctrl_logic.sv
module ctrl_logic
    import repmul_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [ST_USED-1:0] t,
    input  logic               z,
    output ctl_t               ctl,
    output logic               load,
    output logic [CNT_W-1:0]   load_val
);
    localparam logic [CNT_W-1:0] LOOP_CODE = CNT_W'(ST_LOOP);
    localparam logic [CNT_W-1:0] HALT_CODE = CNT_W'(ST_HALT);

    logic go_loop;
    logic go_halt;

    always_comb begin
        go_loop       = t[ST_T3] & ~z;
        go_halt       = t[ST_T5];
        load          = go_loop | go_halt;
        load_val      = ({CNT_W{go_loop}} & LOOP_CODE) | ({CNT_W{go_halt}} & HALT_CODE);

        ctl           = '0;
        ctl.clr_acc   = t[ST_T0];
        ctl.ld_mcand  = t[ST_T0];
        ctl.ld_mplier = t[ST_T1];
        ctl.add_en    = t[ST_T2];
        ctl.dec_cnt   = t[ST_T2];
        ctl.wr_acc    = t[ST_T2];
        ctl.drive_out = t[ST_T4];
    end
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
    import repmul_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] in_bus,
    output logic [DATA_W-1:0] out_bus,
    output logic              z
);
    localparam logic [DATA_W-1:0] D_ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] mcand;
        logic [DATA_W-1:0] cnt;
    } dp_t;

    dp_t d_d, d_q;
    logic [DATA_W-1:0] sum;

    always_comb begin
        // Adder result, carry out dropped: product is modulo 2**DATA_W.
        sum = ctl.add_en ? (d_q.acc + d_q.mcand) : d_q.acc;
        d_d = d_q;
        if (ctl.clr_acc)   d_d.acc   = '0;
        if (ctl.wr_acc)    d_d.acc   = sum;
        if (ctl.ld_mcand)  d_d.mcand = in_bus;
        if (ctl.ld_mplier) d_d.cnt   = in_bus;
        if (ctl.dec_cnt)   d_d.cnt   = d_q.cnt - D_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign z       = (d_q.cnt == '0);
    assign out_bus = ctl.drive_out ? d_q.acc : '0;
endmodule

// File: rtl/rep_add_mult.sv
module rep_add_mult
    import repmul_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_bus,
    output logic [DATA_W-1:0] out_bus,
    output logic              out_valid
);
    logic [CNT_W-1:0]   state_q;
    logic [ST_USED-1:0] t;
    logic               z;
    logic               load;
    logic [CNT_W-1:0]   load_val;
    ctl_t               ctl;

    seq_counter #(.CNT_W(CNT_W)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .cnt_q    (state_q)
    );

    timing_decoder #(.CNT_W(CNT_W), .N_OUT(ST_USED)) i_dec (
        .cnt (state_q),
        .t   (t)
    );

    ctrl_logic #(.CNT_W(CNT_W)) i_ctrl (
        .t        (t),
        .z        (z),
        .ctl      (ctl),
        .load     (load),
        .load_val (load_val)
    );

    mult_datapath #(.DATA_W(DATA_W)) i_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .in_bus  (in_bus),
        .out_bus (out_bus),
        .z       (z)
    );

    assign out_valid = t[ST_T4];
endmodule

// File: rtl/repmul_checker.sv
module repmul_checker
    import repmul_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] out_bus,
    input logic              out_valid,
    input logic [CNT_W-1:0]  state_q,
    input logic              z
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (state_q == CNT_W'(ST_T0)) && !out_valid);

    assert_operand_order_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CNT_W'(ST_T0)) |=> (state_q == CNT_W'(ST_T1)));

    assert_loop_back_R3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CNT_W'(ST_T3)) && !z) |=> (state_q == CNT_W'(ST_T2)));

    assert_exit_R4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CNT_W'(ST_T3)) && z) |=> out_valid);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_bus == '0));

    assert_park_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CNT_W'(ST_T5)) |=> (state_q == CNT_W'(ST_T5)));
endmodule

bind rep_add_mult repmul_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .out_bus   (out_bus),
    .out_valid (out_valid),
    .state_q   (state_q),
    .z         (z)
);

// File: tb/test_rep_add_mult.sv
`timescale 1ns/1ps
module test_rep_add_mult;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_bus = 4'h0;
    logic [3:0] out_bus;
    logic       out_valid;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    rep_add_mult i_rep_add_mult (
        .clk       (clk),
        .rst       (rst),
        .in_bus    (in_bus),
        .out_bus   (out_bus),
        .out_valid (out_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Resets (R1), loads operands (R2), then watches every cycle (R3..R6).
    task automatic do_run(input logic [3:0] m, input logic [3:0] q, input string tag);
        int n     = (q == 4'd0) ? 16 : int'(q);
        int exp   = (int'(m) * int'(q)) % 16;
        int exp_k = 2 + 2 * n;
        @(negedge clk);
        rst = 1'b1; in_bus = 4'hA;
        @(negedge clk);
        chk(out_valid == 1'b0, {"R1 valid in reset ", tag}, int'(out_valid), 0);
        chk(out_bus == 4'd0, {"R1 bus in reset ", tag}, int'(out_bus), 0);
        rst = 1'b0; in_bus = m;          // cycle 0
        @(negedge clk);
        in_bus = q;                      // cycle 1
        for (int k = 2; k <= exp_k + 6; k++) begin
            @(negedge clk);
            if (k == exp_k) begin
                chk(out_valid == 1'b1, {"R4 valid at 2+2n ", tag}, int'(out_valid), 1);
                chk(int'(out_bus) == exp, {"R4 R3 R2 product ", tag}, int'(out_bus), exp);
            end else if (k < exp_k) begin
                chk(!out_valid && out_bus == 4'd0, {"R5 quiet before result ", tag},
                    int'({out_valid, out_bus}), 0);
            end else begin
                chk(!out_valid && out_bus == 4'd0, {"R6 parked after result ", tag},
                    int'({out_valid, out_bus}), 0);
            end
            in_bus = 4'(k * 5 + 3);      // later bus values must be ignored (R2, R6)
        end
    endtask

    task automatic t_basic;       do_run(4'd3, 4'd4, "3x4");   endtask
    task automatic t_modulo;      do_run(4'd7, 4'd5, "7x5");   do_run(4'd15, 4'd15, "15x15"); endtask
    task automatic t_one;         do_run(4'd9, 4'd1, "9x1");   endtask
    task automatic t_zero_mplier; do_run(4'd5, 4'd0, "R7 5x0"); endtask
    task automatic t_zero_mcand;  do_run(4'd0, 4'd6, "R8 0x6"); endtask

    task automatic t_mid_reset;   // R9
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_bus = 4'd7;
        @(negedge clk);
        in_bus = 4'd9;
        repeat (5) @(negedge clk);
        do_run(4'd2, 4'd3, "R9 restart 2x3");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_basic();
        t_modulo();
        t_one();
        t_zero_mplier();
        t_zero_mcand();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule